// File: doc/BRIEF.md
# Four-Phase Accumulator Processor

This block is a small 8-bit accumulator machine. It has one internal memory of 64 words of 8 bits, which holds both code and data. Every instruction takes exactly four clock cycles: two fetch steps followed by two execute steps. A two-bit wrapping counter names the current step. A hardwired command block combines that step with the decoded instruction and produces single-cycle control strobes. These strobes load the instruction register, load or bump the program counter, clear, load, invert or shift the accumulator, write memory and steer the memory address mux.

An instruction word keeps its operation class in bits 7:6 and a 6-bit address in bits 5:0. A host loads a program through a write port while init is held. It then releases init and watches the program counter, accumulator, instruction register and halt flag. A stop instruction freezes the machine. A start pulse lets it continue with the next word in memory.

Top module: `acc_cpu`

## Requirements
- R1: While init is high, PC, accumulator and instruction register read 0 and the halt flag is low. Execution begins at address 0 on the first rising edge after init falls. Holding init high and pulsing the load port writes memory.
- R2: Each instruction takes four cycles, in the order fetch-1, fetch-2, exec-1, exec-2. After fetch-2 the instruction register holds the word at the old PC and the PC equals the old PC plus one.
- R3: Class 10 (ADD, word 0x80|addr) sets A to (A + M[addr]) mod 256, with no carry kept.
- R4: Class 11 (MEM, word 0xC0|addr) writes A into M[addr]. The write happens only in exec-1, with the address mux on the instruction's address field.
- R5: Class 01 (JMP, word 0x40|addr) loads addr into the PC.
- R6: In class 00, bits 5:3 pick the operation. CLA (code 1, word 0x08) sets A to 0. CPL (code 2, word 0x10) inverts every bit of A. NOP (code 0, word 0x00) changes nothing.
- R7: SHR (code 3, word 0x18) shifts A right by one and SHL (code 4, word 0x20) shifts A left by one. A zero enters the vacated bit in both cases.
- R8: SKIPO (code 5, word 0x28) adds an extra 1 to the PC when A bit 0 is 1. SKIPN (code 6, word 0x30) does the same when A bit 7 is 1. Otherwise neither one has any effect.
- R9: STOP (code 7, word 0x38) raises the halt flag and freezes PC, A and IR. While halted, a start pulse clears the flag on the next edge. The following four cycles then run the word at the current PC.
- R10: The start input has no effect while the machine is running. Bits 2:0 of a class-00 word have no effect.
- R11: The PC is 6 bits wide and wraps from 63 to 0.
- R12: The address mux leaves the PC only during exec-1 of ADD or MEM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_i | input | 1 | Asynchronous active-high init |
| start_i | input | 1 | Resume after a stop |
| prog_we_i | input | 1 | Memory load strobe |
| prog_addr_i | input | 6 | Memory load address |
| prog_data_i | input | 8 | Memory load data |
| pc_o | output | 6 | Program counter |
| acc_o | output | 8 | Accumulator |
| ir_o | output | 8 | Instruction register |
| halted_o | output | 1 | Halt flag |

## Verification
The bench runs one program that uses every operation at least once. The first ADD pair overflows past 255, which shows that the sum wraps and no carry is kept. Each skip is run once with its bit set and once with it clear, so a wrong bit choice or a missing condition shows up as a wrong PC. A MEM followed by an ADD from the same address, a CLA with junk in its low bits, start held high while running, a jump to 62 with a stop at 63, and two resumes from halt cover, in turn, the memory write path, ignored fields, the ignored start, PC wrap and the extra resume cycle.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    PH_F1 = 2'd0,
    PH_F2 = 2'd1,
    PH_X1 = 2'd2,
    PH_X2 = 2'd3
  } phase_t;

  localparam logic [1:0] CLS_GRP = 2'b00;
  localparam logic [1:0] CLS_JMP = 2'b01;
  localparam logic [1:0] CLS_ADD = 2'b10;
  localparam logic [1:0] CLS_MEM = 2'b11;

  localparam int G_NOP   = 0;
  localparam int G_CLA   = 1;
  localparam int G_CPL   = 2;
  localparam int G_SHR   = 3;
  localparam int G_SHL   = 4;
  localparam int G_SKIPO = 5;
  localparam int G_SKIPN = 6;
  localparam int G_STOP  = 7;
  localparam int GRP_N   = 8;

  typedef struct packed {
    logic             is_jmp;
    logic             is_add;
    logic             is_mem;
    logic [GRP_N-1:0] grp;
  } dec_t;

  typedef struct packed {
    logic ld_ir;
    logic inc_pc;
    logic ld_pc;
    logic sel_ir;
    logic ld_opnd;
    logic we;
    logic ld_a;
    logic rst_a;
    logic cpl_a;
    logic shr_a;
    logic shl_a;
    logic halt;
  } cmd_t;

endpackage

// File: rtl/cpu_phase_gen.sv
module cpu_phase_gen
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   init_i,
  input  logic   start_i,
  input  logic   halt_cmd_i,
  output phase_t phase_o,
  output logic   halted_o,
  output logic   run_o
);

  phase_t phase_q;
  logic   halted_q;

  always_ff @(posedge clk or posedge init_i) begin
    if (init_i) begin
      phase_q  <= PH_F1;
      halted_q <= 1'b0;
    end else if (halted_q) begin
      if (start_i) halted_q <= 1'b0;
    end else if (halt_cmd_i) begin
      halted_q <= 1'b1;
      phase_q  <= PH_F1;
    end else begin
      phase_q <= phase_t'(phase_q + 2'd1);
    end
  end

  assign phase_o  = phase_q;
  assign halted_o = halted_q;
  assign run_o    = ~halted_q;

endmodule

// File: rtl/cpu_decoder.sv
module cpu_decoder
  import acc_cpu_pkg::*;
(
  input  logic [1:0] cls_i,
  input  logic [2:0] sub_i,
  output dec_t       dec_o
);

  assign dec_o.is_jmp = (cls_i == CLS_JMP);
  assign dec_o.is_add = (cls_i == CLS_ADD);
  assign dec_o.is_mem = (cls_i == CLS_MEM);

  for (genvar k = 0; k < GRP_N; k++) begin : g_grp
    assign dec_o.grp[k] = (cls_i == CLS_GRP) && (sub_i == 3'(k));
  end

endmodule

// File: rtl/cpu_cmd_block.sv
module cpu_cmd_block
  import acc_cpu_pkg::*;
(
  input  phase_t phase_i,
  input  logic   run_i,
  input  dec_t   dec_i,
  input  logic   acc_lsb_i,
  input  logic   acc_msb_i,
  output cmd_t   cmd_o
);

  logic in_f1, in_f2, in_x1, in_x2;
  logic skip_hit;

  assign in_f1 = run_i && (phase_i == PH_F1);
  assign in_f2 = run_i && (phase_i == PH_F2);
  assign in_x1 = run_i && (phase_i == PH_X1);
  assign in_x2 = run_i && (phase_i == PH_X2);

  assign skip_hit = (dec_i.grp[G_SKIPO] && acc_lsb_i) ||
                    (dec_i.grp[G_SKIPN] && acc_msb_i);

  always_comb begin
    cmd_o         = '0;
    cmd_o.ld_ir   = in_f1;
    cmd_o.inc_pc  = in_f2 || (in_x1 && skip_hit);
    cmd_o.ld_pc   = in_x1 && dec_i.is_jmp;
    cmd_o.sel_ir  = in_x1 && (dec_i.is_add || dec_i.is_mem);
    cmd_o.ld_opnd = in_x1 && dec_i.is_add;
    cmd_o.we      = in_x1 && dec_i.is_mem;
    cmd_o.rst_a   = in_x1 && dec_i.grp[G_CLA];
    cmd_o.ld_a    = in_x2 && dec_i.is_add;
    cmd_o.cpl_a   = in_x2 && dec_i.grp[G_CPL];
    cmd_o.shr_a   = in_x2 && dec_i.grp[G_SHR];
    cmd_o.shl_a   = in_x2 && dec_i.grp[G_SHL];
    cmd_o.halt    = in_x2 && dec_i.grp[G_STOP];
  end

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              init_i,
  input  cmd_t              cmd_i,
  input  logic              prog_we_i,
  input  logic [DATA_W-3:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  output logic [DATA_W-3:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] acc_o
);

  localparam int ADDR_W = DATA_W - 2;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] f_add(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] f_shr(input logic [DATA_W-1:0] a);
    return {1'b0, a[DATA_W-1:1]};
  endfunction

  function automatic logic [DATA_W-1:0] f_shl(input logic [DATA_W-1:0] a);
    return {a[DATA_W-2:0], 1'b0};
  endfunction

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q, acc_q, opnd_q;
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] rd_w;

  assign addr_w = cmd_i.sel_ir ? ir_q[ADDR_W-1:0] : pc_q;
  assign rd_w   = mem_q[addr_w];

  always_ff @(posedge clk) begin
    if (prog_we_i)     mem_q[prog_addr_i] <= prog_data_i;
    else if (cmd_i.we) mem_q[addr_w]      <= acc_q;
  end

  always_ff @(posedge clk or posedge init_i) begin
    if (init_i) begin
      pc_q   <= '0;
      ir_q   <= '0;
      acc_q  <= '0;
      opnd_q <= '0;
    end else begin
      if (cmd_i.ld_ir)   ir_q   <= rd_w;
      if (cmd_i.ld_opnd) opnd_q <= rd_w;
      if (cmd_i.ld_pc)        pc_q <= ir_q[ADDR_W-1:0];
      else if (cmd_i.inc_pc)  pc_q <= pc_q + 1'b1;
      if (cmd_i.rst_a)        acc_q <= '0;
      else if (cmd_i.ld_a)    acc_q <= f_add(acc_q, opnd_q);
      else if (cmd_i.cpl_a)   acc_q <= ~acc_q;
      else if (cmd_i.shr_a)   acc_q <= f_shr(acc_q);
      else if (cmd_i.shl_a)   acc_q <= f_shl(acc_q);
    end
  end

  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              init_i,
  input  logic              start_i,
  input  logic              prog_we_i,
  input  logic [DATA_W-3:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  output logic [DATA_W-3:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic              halted_o
);

  phase_t phase_w;
  logic   halted_w, run_w;
  dec_t   dec_w;
  cmd_t   cmd_w;

  cpu_phase_gen u_phase (
    .clk        (clk),
    .init_i     (init_i),
    .start_i    (start_i),
    .halt_cmd_i (cmd_w.halt),
    .phase_o    (phase_w),
    .halted_o   (halted_w),
    .run_o      (run_w)
  );

  cpu_decoder u_dec (
    .cls_i (ir_o[DATA_W-1:DATA_W-2]),
    .sub_i (ir_o[DATA_W-3:DATA_W-5]),
    .dec_o (dec_w)
  );

  cpu_cmd_block u_cmd (
    .phase_i   (phase_w),
    .run_i     (run_w),
    .dec_i     (dec_w),
    .acc_lsb_i (acc_o[0]),
    .acc_msb_i (acc_o[DATA_W-1]),
    .cmd_o     (cmd_w)
  );

  cpu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .init_i      (init_i),
    .cmd_i       (cmd_w),
    .prog_we_i   (prog_we_i),
    .prog_addr_i (prog_addr_i),
    .prog_data_i (prog_data_i),
    .pc_o        (pc_o),
    .ir_o        (ir_o),
    .acc_o       (acc_o)
  );

  assign halted_o = halted_w;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              init_i,
  input logic              start_i,
  input logic [1:0]        phase,
  input logic              halted,
  input cmd_t              cmd,
  input logic [DATA_W-3:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] ir
);

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (init_i)
    !halted |=> phase == $past(phase) + 2'd1);

  assert_pc_bump_R2: assert property (@(posedge clk) disable iff (init_i)
    (!halted && phase == 2'd1) |=> pc == (DATA_W-2)'($past(pc) + 1'b1));

  assert_write_steered_R4: assert property (@(posedge clk) disable iff (init_i)
    cmd.we |-> cmd.sel_ir);

  assert_pc_single_R8: assert property (@(posedge clk) disable iff (init_i)
    $onehot0({cmd.ld_pc, cmd.inc_pc}));

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (init_i)
    (halted && !start_i) |=> ($stable(pc) && $stable(acc) && $stable(ir)));

  assert_halt_phase_R9: assert property (@(posedge clk) disable iff (init_i)
    halted |-> phase == 2'd0);

  assert_mux_window_R12: assert property (@(posedge clk) disable iff (init_i)
    cmd.sel_ir |-> (phase == 2'd2 && !halted));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .init_i  (init_i),
  .start_i (start_i),
  .phase   (phase_w),
  .halted  (halted_w),
  .cmd     (cmd_w),
  .pc      (pc_o),
  .acc     (acc_o),
  .ir      (ir_o)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

  logic       clk = 1'b0;
  logic       init_i = 1'b1;
  logic       start_i = 1'b0;
  logic       prog_we_i = 1'b0;
  logic [5:0] prog_addr_i = '0;
  logic [7:0] prog_data_i = '0;
  logic [5:0] pc_o;
  logic [7:0] acc_o, ir_o;
  logic       halted_o;

  always #2 clk = ~clk;

  acc_cpu uut (
    .clk(clk), .init_i(init_i), .start_i(start_i),
    .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
    .pc_o(pc_o), .acc_o(acc_o), .ir_o(ir_o), .halted_o(halted_o)
  );

  typedef struct {
    logic [5:0] pc;
    logic [7:0] acc;
    logic [7:0] ir;
    logic       halted;
    string      tag;
  } item_t;

  item_t q[$];
  event  done_ev;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  logic [7:0] bm [64];
  logic [5:0] m_pc;
  logic [7:0] m_acc, m_ir;
  logic       m_halt;

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Reference model of one instruction, written from the requirements
  task automatic model_step();
    logic [1:0] cls;
    logic [2:0] sub;
    logic [5:0] a;
    if (m_halt) return;
    m_ir = bm[m_pc];
    m_pc = m_pc + 6'd1;
    cls = m_ir[7:6];
    sub = m_ir[5:3];
    a   = m_ir[5:0];
    case (cls)
      2'b01: m_pc = a;
      2'b10: m_acc = m_acc + bm[a];
      2'b11: bm[a] = m_acc;
      default: case (sub)
        3'd1: m_acc = 8'h00;
        3'd2: m_acc = ~m_acc;
        3'd3: m_acc = m_acc >> 1;
        3'd4: m_acc = m_acc << 1;
        3'd5: if (m_acc[0]) m_pc = m_pc + 6'd1;
        3'd6: if (m_acc[7]) m_pc = m_pc + 6'd1;
        3'd7: m_halt = 1'b1;
        default: ;
      endcase
    endcase
  endtask

  // Driver: predicts, pushes, runs four cycles, hands over to the monitor
  task automatic run_instr(input string tag, input bit hold_start, input bit mid);
    item_t it;
    logic [5:0] pc0;
    logic [7:0] w0;
    pc0 = m_pc;
    w0  = bm[m_pc];
    model_step();
    it.pc = m_pc; it.acc = m_acc; it.ir = m_ir; it.halted = m_halt; it.tag = tag;
    q.push_back(it);
    start_i = hold_start;
    if (mid) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2", "ir after fetch", ir_o, w0);
      check("R2", "pc after fetch", {2'b00, pc_o}, {2'b00, pc0 + 6'd1});
      repeat (2) @(posedge clk);
    end else begin
      repeat (4) @(posedge clk);
    end
    @(negedge clk);
    start_i = 1'b0;
    -> done_ev;
    #0.1;
  endtask

  task automatic resume();
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    m_halt = 1'b0;
    check("R9", "halt after start", {7'd0, halted_o}, 8'h00);
  endtask

  task automatic load(input logic [5:0] a, input logic [7:0] d);
    prog_we_i = 1'b1; prog_addr_i = a; prog_data_i = d;
    bm[a] = d;
    @(posedge clk);
    @(negedge clk);
    prog_we_i = 1'b0;
  endtask

  // Monitor: pops predictions and compares them to the ports
  initial begin
    item_t e;
    forever begin
      @(done_ev);
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor empty queue actual=0 expected=1");
      end else begin
        e = q.pop_front();
        check(e.tag, "pc", {2'b00, pc_o}, {2'b00, e.pc});
        check(e.tag, "acc", acc_o, e.acc);
        check(e.tag, "ir", ir_o, e.ir);
        check(e.tag, "halted", {7'd0, halted_o}, {7'd0, e.halted});
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    m_pc = 0; m_acc = 0; m_ir = 0; m_halt = 0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) load(6'(i), 8'h00);
    load(0, 8'h08);  load(1, 8'hA8);  load(2, 8'hA9);  load(3, 8'h20);
    load(4, 8'h10);  load(5, 8'h30);  load(6, 8'h08);  load(7, 8'h18);
    load(8, 8'h28);  load(9, 8'h08);  load(10, 8'hEA); load(11, 8'h0F);
    load(12, 8'hAA); load(13, 8'h30); load(14, 8'h00); load(15, 8'h20);
    load(16, 8'h28); load(17, 8'h38); load(18, 8'h7E); load(62, 8'h18);
    load(63, 8'h38); load(40, 8'h7F); load(41, 8'h95);

    // R1 reset state
    check("R1", "pc in init", {2'b00, pc_o}, 8'h00);
    check("R1", "acc in init", acc_o, 8'h00);
    check("R1", "ir in init", ir_o, 8'h00);
    check("R1", "halt in init", {7'd0, halted_o}, 8'h00);
    init_i = 1'b0;

    run_instr("R6", 0, 1);   // CLA, with mid-fetch R2 check
    run_instr("R3", 0, 0);   // ADD 0x7F
    run_instr("R3", 0, 0);   // ADD 0x95 -> wraps
    run_instr("R10", 1, 0);  // SHL with start held
    run_instr("R6", 0, 0);   // CPL
    run_instr("R8", 0, 0);   // SKIPN taken
    run_instr("R7", 0, 0);   // SHR
    run_instr("R8", 0, 0);   // SKIPO taken
    run_instr("R4", 0, 0);   // MEM 42
    run_instr("R10", 0, 0);  // CLA with low bits set
    run_instr("R4", 0, 1);   // ADD 42 reads the stored value
    run_instr("R8", 0, 0);   // SKIPN not taken
    run_instr("R6", 0, 0);   // NOP
    run_instr("R7", 0, 0);   // SHL
    run_instr("R8", 0, 0);   // SKIPO not taken
    run_instr("R9", 0, 0);   // STOP
    run_instr("R9", 0, 0);   // frozen
    run_instr("R9", 0, 0);   // frozen
    resume();
    run_instr("R5", 0, 0);   // JMP 62
    run_instr("R7", 0, 0);   // SHR at 62
    run_instr("R11", 0, 0);  // STOP at 63, PC wraps to 0
    check("R11", "pc wrapped", {2'b00, pc_o}, 8'h00);
    resume();
    run_instr("R9", 0, 0);   // resumes at 0: CLA
    run_instr("R3", 0, 0);
    run_instr("R3", 0, 0);

    init_i = 1'b1;
    #1;
    check("R1", "pc on re-init", {2'b00, pc_o}, 8'h00);
    check("R1", "acc on re-init", acc_o, 8'h00);
    check("R1", "halt on re-init", {7'd0, halted_o}, 8'h00);
    check("R2", "queue drained", 8'(q.size()), 8'h00);
    report();
  end

endmodule